// File: doc/BRIEF.md
# Translation-Table Pointer Register Block

This block sits in a memory-management unit next to the data TLB. After a TLB miss, the tag-access register holds the faulting virtual page and its context number. Software then reads a ready-made pointer into its in-memory translation table instead of computing the hash itself. The block keeps two register sets: one for context zero and one for every other context. Each set has a base register for each of two page-size classes (A and B) and one configuration register. The tag-access context field picks which set feeds the pointer. The block also holds the primary and secondary context numbers and the partition number.

All access goes through one register port. A request is presented for one cycle. The response (valid, error, read data) appears on the next cycle. An access to an offset that is not mapped, or a write to a read-only offset, returns an error and changes nothing.

Top module: `tsb_ptr_regs`

## Requirements
- R1: After reset every register reads as zero. The tag-target word and both pointer words also read as zero.
- R2: Every request cycle is answered by `rspValid` high in exactly the next cycle. No response appears without a request.
- R3: Writable offsets read back what was written. Offsets: 0x08 primary context and 0x10 secondary context, each keeping bits 12:0. 0x30 tag access. 0x80 partition, keeping bits 7:0. Context-zero set: 0x40 base A, 0x48 base B, 0x50 config. Nonzero-context set: 0x58 base A, 0x60 base B, 0x68 config. These keep all 64 bits, and unkept bits read as zero.
- R4: Offset 0x00 (read-only) returns the tag target. Tag-access bits 63:22 sit in bits 41:0, tag-access bits 12:0 sit in bits 60:48, and all other bits are zero.
- R5: When tag-access bits 12:0 are zero, the pointers use the context-zero base and config registers. Otherwise they use the nonzero-context set.
- R6: Offset 0x90 (read-only) returns pointer A. Take the selected base A with bits 12:0 cleared. OR into it bits 12+T down to 4 of the tag-access value shifted right by 9+3·P. Here T is base bits 3:0 and P is config bits 2:0.
- R7: Offset 0x98 (read-only) returns pointer B. It uses the same formula with the selected base B. In addition, if base B bit 12 is set, the bit at position 13+T is also set.
- R8: These accesses return `rspError`=1 with read data zero and change no register: a read or write to any other offset, and a write to 0x00, 0x90 or 0x98.
- R9: Successful writes return read data zero. A read issued in the cycle after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Register offset |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspError | output | 1 | Unmapped offset or write to a read-only offset |
| rspRdata | output | 64 | Read data, zero on writes and errors |

## Verification
On every cycle, the assertions check the one-cycle response rule and that error responses carry no data. They also check that no register moves unless a write is accepted, and that both pointers have their low four bits clear. The pointer arithmetic can only be shown by the bench's scenarios. These are: the shift and mask for every page-size code, the context-class switch on a zero or nonzero context field, the split bit, and the tag-target packing. The bench compares read data against a reference model under random and directed traffic.

// File: rtl/tsbptr_pkg.sv
package tsbptr_pkg;
  localparam int DATA_W = 64;
  localparam int CTX_W  = 13;
  localparam int OFF_W  = 8;

  localparam logic [OFF_W-1:0] OFF_TT       = 8'h00;
  localparam logic [OFF_W-1:0] OFF_PRI      = 8'h08;
  localparam logic [OFF_W-1:0] OFF_SEC      = 8'h10;
  localparam logic [OFF_W-1:0] OFF_TAG      = 8'h30;
  localparam logic [OFF_W-1:0] OFF_Z_BASE_A = 8'h40;
  localparam logic [OFF_W-1:0] OFF_Z_BASE_B = 8'h48;
  localparam logic [OFF_W-1:0] OFF_Z_CFG    = 8'h50;
  localparam logic [OFF_W-1:0] OFF_N_BASE_A = 8'h58;
  localparam logic [OFF_W-1:0] OFF_N_BASE_B = 8'h60;
  localparam logic [OFF_W-1:0] OFF_N_CFG    = 8'h68;
  localparam logic [OFF_W-1:0] OFF_PART     = 8'h80;
  localparam logic [OFF_W-1:0] OFF_PTR_A    = 8'h90;
  localparam logic [OFF_W-1:0] OFF_PTR_B    = 8'h98;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TT, SEL_PRI, SEL_SEC, SEL_TAG,
    SEL_ZBA, SEL_ZBB, SEL_ZCFG, SEL_NBA, SEL_NBB, SEL_NCFG,
    SEL_PART, SEL_PTRA, SEL_PTRB
  } regsel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regsel_e sel;
  } strobe_t;
endpackage

// File: rtl/tsbptr_ctrl.sv
module tsbptr_ctrl
  import tsbptr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           strb,
  output logic              rspValid,
  output logic              rspError
);
  regsel_e sel;
  logic    readOnly;
  logic    bad;

  always_comb begin
    sel = SEL_NONE;
    if      (reqAddr == ADDR_W'(OFF_TT))       sel = SEL_TT;
    else if (reqAddr == ADDR_W'(OFF_PRI))      sel = SEL_PRI;
    else if (reqAddr == ADDR_W'(OFF_SEC))      sel = SEL_SEC;
    else if (reqAddr == ADDR_W'(OFF_TAG))      sel = SEL_TAG;
    else if (reqAddr == ADDR_W'(OFF_Z_BASE_A)) sel = SEL_ZBA;
    else if (reqAddr == ADDR_W'(OFF_Z_BASE_B)) sel = SEL_ZBB;
    else if (reqAddr == ADDR_W'(OFF_Z_CFG))    sel = SEL_ZCFG;
    else if (reqAddr == ADDR_W'(OFF_N_BASE_A)) sel = SEL_NBA;
    else if (reqAddr == ADDR_W'(OFF_N_BASE_B)) sel = SEL_NBB;
    else if (reqAddr == ADDR_W'(OFF_N_CFG))    sel = SEL_NCFG;
    else if (reqAddr == ADDR_W'(OFF_PART))     sel = SEL_PART;
    else if (reqAddr == ADDR_W'(OFF_PTR_A))    sel = SEL_PTRA;
    else if (reqAddr == ADDR_W'(OFF_PTR_B))    sel = SEL_PTRB;
  end

  assign readOnly = (sel == SEL_TT) || (sel == SEL_PTRA) || (sel == SEL_PTRB);
  assign bad      = (sel == SEL_NONE) || (reqWrite && readOnly);

  assign strb.sel  = sel;
  assign strb.wrEn = reqValid && reqWrite && !bad;
  assign strb.rdEn = reqValid && !reqWrite && !bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspError <= reqValid && bad;
    end
  end

  // R2: one response per request, exactly one cycle later
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/tsbptr_calc.sv
module tsbptr_calc
  import tsbptr_pkg::*;
#(
  parameter bit SPLIT_EN = 1'b0
) (
  input  logic [DATA_W-1:0] tagVal,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [2:0]        pageCode,
  output logic [DATA_W-1:0] ptrOut
);
  localparam int SH_W = 6;

  logic [3:0]        tblSize;
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] window;
  logic [DATA_W-1:0] core;

  assign tblSize = baseVal[3:0];
  assign shAmt   = SH_W'(9) + SH_W'(pageCode) * SH_W'(3);
  assign shifted = tagVal >> shAmt;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      window[i] = (i >= 4) && (i <= 12 + int'(tblSize));
    end
  end

  assign core = {baseVal[DATA_W-1:13], 13'b0} | (shifted & window);

  generate
    if (SPLIT_EN) begin : g_split
      assign ptrOut = baseVal[12] ? (core | (DATA_W'(1) << (13 + int'(tblSize)))) : core;
    end else begin : g_plain
      logic [10:0] unusedBase;
      assign unusedBase = baseVal[12:2];
      assign ptrOut = core;
    end
  endgenerate
endmodule

// File: rtl/tsbptr_dpath.sv
module tsbptr_dpath
  import tsbptr_pkg::*;
#(
  parameter int PART_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int NUM_CLS = 2;

  logic [DATA_W-1:0] tagAccess;
  logic [CTX_W-1:0]  priCtx, secCtx;
  logic [PART_W-1:0] partId;
  logic [DATA_W-1:0] baseReg [NUM_CLS][NUM_CLS];
  logic [DATA_W-1:0] cfgReg  [NUM_CLS];
  logic [DATA_W-1:0] ptrWord [NUM_CLS];
  logic [DATA_W-1:0] tagTarget;
  logic [DATA_W-1:0] readMux;
  logic              setIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagAccess <= '0;
      priCtx    <= '0;
      secCtx    <= '0;
      partId    <= '0;
      for (int c = 0; c < NUM_CLS; c++) begin
        cfgReg[c] <= '0;
        for (int p = 0; p < NUM_CLS; p++) baseReg[c][p] <= '0;
      end
    end else if (strb.wrEn) begin
      case (strb.sel)
        SEL_TAG:  tagAccess     <= reqWdata;
        SEL_PRI:  priCtx        <= reqWdata[CTX_W-1:0];
        SEL_SEC:  secCtx        <= reqWdata[CTX_W-1:0];
        SEL_PART: partId        <= reqWdata[PART_W-1:0];
        SEL_ZBA:  baseReg[0][0] <= reqWdata;
        SEL_ZBB:  baseReg[0][1] <= reqWdata;
        SEL_ZCFG: cfgReg[0]     <= reqWdata;
        SEL_NBA:  baseReg[1][0] <= reqWdata;
        SEL_NBB:  baseReg[1][1] <= reqWdata;
        SEL_NCFG: cfgReg[1]     <= reqWdata;
        default: ;
      endcase
    end
  end

  // context zero selects set 0, any other context selects set 1
  assign setIdx = (tagAccess[CTX_W-1:0] != '0);

  generate
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_ptr
      tsbptr_calc #(.SPLIT_EN(g == 1)) u_calc (
        .tagVal  (tagAccess),
        .baseVal (baseReg[setIdx][g]),
        .pageCode(cfgReg[setIdx][2:0]),
        .ptrOut  (ptrWord[g])
      );
    end
  endgenerate

  assign tagTarget = {3'b0, tagAccess[CTX_W-1:0], 6'b0, tagAccess[DATA_W-1:22]};

  always_comb begin
    readMux = '0;
    case (strb.sel)
      SEL_TT:   readMux = tagTarget;
      SEL_PRI:  readMux = DATA_W'(priCtx);
      SEL_SEC:  readMux = DATA_W'(secCtx);
      SEL_TAG:  readMux = tagAccess;
      SEL_PART: readMux = DATA_W'(partId);
      SEL_ZBA:  readMux = baseReg[0][0];
      SEL_ZBB:  readMux = baseReg[0][1];
      SEL_ZCFG: readMux = cfgReg[0];
      SEL_NBA:  readMux = baseReg[1][0];
      SEL_NBB:  readMux = baseReg[1][1];
      SEL_NCFG: readMux = cfgReg[1];
      SEL_PTRA: readMux = ptrWord[0];
      SEL_PTRB: readMux = ptrWord[1];
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdEn ? readMux : '0;
  end

  // R8: register state moves only on an accepted write
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> ($stable(tagAccess) && $stable(priCtx) && $stable(secCtx)
                    && $stable(partId) && $stable(cfgReg[0]) && $stable(cfgReg[1])
                    && $stable(baseReg[0][0]) && $stable(baseReg[0][1])
                    && $stable(baseReg[1][0]) && $stable(baseReg[1][1])));

  // R6: pointers always address 16-byte entries
  p_ptr_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWord[0][3:0] == 4'b0) && (ptrWord[1][3:0] == 4'b0));
endmodule

// File: rtl/tsb_ptr_regs.sv
module tsb_ptr_regs
  import tsbptr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PART_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic              rspError,
  output logic [63:0]       rspRdata
);
  strobe_t strb;

  tsbptr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strb    (strb),
    .rspValid(rspValid),
    .rspError(rspError)
  );

  tsbptr_dpath #(.PART_W(PART_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqWdata(reqWdata),
    .rdData  (rspRdata)
  );

  // R8: an error response carries no data and always comes with rspValid
  p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (rspValid && rspRdata == 64'b0));
endmodule

// File: tb/tsb_ptr_regs_tb.sv
module tsb_ptr_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        rspValid, rspError;
  logic [63:0] rspRdata;

  int checks = 0;
  int errors = 0;

  logic [63:0] mTag, mPri, mSec, mPart;
  logic [63:0] mBase [2][2];
  logic [63:0] mCfg [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsb_ptr_regs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isMapped(input logic [7:0] a);
    case (a)
      8'h00, 8'h08, 8'h10, 8'h30, 8'h40, 8'h48, 8'h50,
      8'h58, 8'h60, 8'h68, 8'h80, 8'h90, 8'h98: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit isRo(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h90) || (a == 8'h98);
  endfunction

  function automatic logic [63:0] ptrModel(input logic [63:0] tag, input logic [63:0] base,
                                           input logic [63:0] cfg, input bit classB);
    int t = int'(base[3:0]);
    int sh = 9 + 3 * int'(cfg[2:0]);
    logic [63:0] s = tag >> sh;
    logic [63:0] r = base & ~64'h1FFF;
    for (int i = 4; i <= 12 + t; i++) r[i] = r[i] | s[i];
    if (classB && base[12]) r[13 + t] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] expRead(input logic [7:0] a);
    int k = (mTag[12:0] == 13'd0) ? 0 : 1;
    logic [63:0] tt = '0;
    tt[41:0]  = mTag[63:22];
    tt[60:48] = mTag[12:0];
    case (a)
      8'h00: return tt;
      8'h08: return mPri;
      8'h10: return mSec;
      8'h30: return mTag;
      8'h40: return mBase[0][0];
      8'h48: return mBase[0][1];
      8'h50: return mCfg[0];
      8'h58: return mBase[1][0];
      8'h60: return mBase[1][1];
      8'h68: return mCfg[1];
      8'h80: return mPart;
      8'h90: return ptrModel(mTag, mBase[k][0], mCfg[k], 1'b0);
      8'h98: return ptrModel(mTag, mBase[k][1], mCfg[k], 1'b1);
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    case (a)
      8'h00: return "R4";
      8'h90: return "R6";
      8'h98: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [63:0] d);
    case (a)
      8'h08: mPri = {51'b0, d[12:0]};
      8'h10: mSec = {51'b0, d[12:0]};
      8'h30: mTag = d;
      8'h40: mBase[0][0] = d;
      8'h48: mBase[0][1] = d;
      8'h50: mCfg[0] = d;
      8'h58: mBase[1][0] = d;
      8'h60: mBase[1][1] = d;
      8'h68: mCfg[1] = d;
      8'h80: mPart = {56'b0, d[7:0]};
      default: ;
    endcase
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [63:0] d, input string req);
    bit expErr = !isMapped(a) || (wr && isRo(a));
    logic [63:0] exp = (wr || expErr) ? 64'b0 : expRead(a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", 64'(rspValid), 64'd1);
    chk(expErr ? "R8" : "R9", 64'(rspError), 64'(expErr));
    chk(wr ? "R9" : (req.len() != 0 ? req : reqOf(a)), rspRdata, exp);
    if (wr && !expErr) modelWrite(a, d);
  endtask

  task automatic readAll(input string req);
    logic [7:0] offs [13] = '{8'h00, 8'h08, 8'h10, 8'h30, 8'h40, 8'h48, 8'h50,
                              8'h58, 8'h60, 8'h68, 8'h80, 8'h90, 8'h98};
    for (int i = 0; i < 13; i++) access(1'b0, offs[i], 64'b0, req);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mTag = '0; mPri = '0; mSec = '0; mPart = '0;
    for (int c = 0; c < 2; c++) begin
      mCfg[c] = '0;
      for (int p = 0; p < 2; p++) mBase[c][p] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything zero after reset
    readAll("R1");

    // R2: no response without a request
    @(negedge clk);
    chk("R2", 64'(rspValid), 64'd0);

    // R3: width truncation of context and partition registers
    access(1'b1, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, "");
    access(1'b0, 8'h08, 64'b0, "R3");
    access(1'b1, 8'h80, 64'h1234_5678_9ABC_DEF0, "");
    access(1'b0, 8'h80, 64'b0, "R3");

    // R4: tag target packing
    access(1'b1, 8'h30, 64'hFEDC_BA98_7654_3ABC, "");
    access(1'b0, 8'h00, 64'b0, "R4");

    // R5: context class select, zero vs nonzero context field
    access(1'b1, 8'h40, 64'h0000_0040_0000_0003, "");
    access(1'b1, 8'h50, 64'h0000_0000_0000_0001, "");
    access(1'b1, 8'h58, 64'h0000_0080_0000_2005, "");
    access(1'b1, 8'h68, 64'h0000_0000_0000_0005, "");
    access(1'b1, 8'h30, 64'h0123_4567_89AB_C000, "");
    access(1'b0, 8'h90, 64'b0, "R5");
    access(1'b1, 8'h30, 64'h0123_4567_89AB_C001, "");
    access(1'b0, 8'h90, 64'b0, "R5");

    // R7: split bit on and off for pointer B
    access(1'b1, 8'h60, 64'h0000_0100_0000_1007, "");
    access(1'b0, 8'h98, 64'b0, "R7");
    access(1'b1, 8'h60, 64'h0000_0100_0000_0007, "");
    access(1'b0, 8'h98, 64'b0, "R7");

    // R6: every page-size code, largest table size
    for (int ps = 0; ps < 8; ps++) begin
      access(1'b1, 8'h68, 64'(ps), "");
      access(1'b1, 8'h58, 64'hA5A5_0000_0000_000F, "");
      access(1'b1, 8'h30, 64'hFFFF_FFFF_FFFF_E07F, "");
      access(1'b0, 8'h90, 64'b0, "R6");
    end

    // R8: errors leave state unchanged
    access(1'b0, 8'h18, 64'b0, "R8");
    access(1'b1, 8'h18, 64'hDEAD_BEEF_DEAD_BEEF, "R8");
    access(1'b1, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF, "R8");
    access(1'b1, 8'h90, 64'hDEAD_BEEF_DEAD_BEEF, "R8");
    access(1'b1, 8'h98, 64'hDEAD_BEEF_DEAD_BEEF, "R8");
    readAll("R8");

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [7:0] a;
      logic [63:0] d = {$urandom, $urandom};
      bit wr = ($urandom % 2) == 1;
      case ($urandom % 16)
        0: a = 8'h00;  1: a = 8'h08;  2: a = 8'h10;  3: a = 8'h30;
        4: a = 8'h40;  5: a = 8'h48;  6: a = 8'h50;  7: a = 8'h58;
        8: a = 8'h60;  9: a = 8'h68;  10: a = 8'h80; 11: a = 8'h90;
        12: a = 8'h98; 13: a = 8'h90; 14: a = 8'h98;
        default: a = 8'($urandom);
      endcase
      if (a == 8'h30 && ($urandom % 2) == 1) d[12:0] = '0;
      access(wr, a, d, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule